// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address. It reads up to four 64-bit table entries through a single-outstanding memory read port. The walk starts from a table base input. Each level contributes a 9-bit index, and the walk ends early when it reaches a 1 GB or 2 MB large page. Before any memory traffic, the block rejects addresses whose upper bits are not a sign extension of bit 47. Such an address raises a protection fault straight away.

A client pulses `start_i` while the walker is idle and presents the virtual address and table base in that cycle. It then waits for a one-cycle `done_o` or `fault_o` pulse. All results stay on the outputs until the next walk is accepted:

- the physical address, the page size and the no-execute summary;
- on a fault, the cause, the level and the virtual address.

The memory side holds a request with a stable address until a response arrives. The response may come any number of cycles later.

Top module: `pt_walker`

## Requirements
- R1: If `va_i[63:47]` are not all equal at an accepted start, `fault_o` pulses in the next cycle. It reports cause 2 (non-canonical), level 0 and `fault_va_o` equal to `va_i`, and no memory request is ever made for that walk.
- R2: The first read address is `{ptbr_i[51:12], va_i[47:39], 3'b000}`. The low 12 bits of the table base are ignored.
- R3: The read address for level L (1 to 3) is `{E[51:12], idx, 3'b000}`, where E is the entry returned at level L-1. The index idx is `va[38:30]`, `va[29:21]` or `va[20:12]` for L = 1, 2, 3. Entry bits 63:52 and 11:0 have no effect on it.
- R4: An entry with bit 0 clear ends the walk. `fault_o` pulses with cause 1 (not present), `fault_level_o` equal to the level of that entry (0 to 3) and `fault_va_o` equal to the walked address.
- R5: A present level-1 entry with bit 7 set ends the walk as a 1 GB page. `pa_o` is `{E[51:30], va[29:0]}` and `size_o` is 2.
- R6: A present level-2 entry with bit 7 set ends the walk as a 2 MB page. `pa_o` is `{E[51:21], va[20:0]}` and `size_o` is 1.
- R7: A present level-3 entry ends the walk as a 4 KB page. `pa_o` is `{E[51:12], va[11:0]}` and `size_o` is 0. Bit 7 has no effect at levels 0 and 3.
- R8: On `done_o`, `nx_o` is the OR of bit 63 over every entry read in that walk.
- R9: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` or `fault_o` pulses, and is low in that cycle. A `start_i` while busy is ignored: it changes neither the requests nor the result.
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rvalid_i` is seen. At most one read is outstanding, and `mem_rvalid_i` while no request is open has no effect.
- R11: `done_o` and `fault_o` are single-cycle pulses and never high together. Cause 0 accompanies `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| va_i | input | 64 | Virtual address to translate |
| ptbr_i | input | 64 | Top-level table base, 4 KB aligned |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse: translation ready |
| fault_o | output | 1 | One-cycle pulse: walk aborted |
| pa_o | output | 52 | Translated physical address |
| size_o | output | 2 | Page size: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| nx_o | output | 1 | No-execute seen on any walked entry |
| cause_o | output | 2 | 0 none, 1 not present, 2 non-canonical |
| fault_level_o | output | 2 | Level at which the walk stopped |
| fault_va_o | output | 64 | Virtual address of the last accepted walk |
| mem_req_o | output | 1 | Read request open |
| mem_addr_o | output | 52 | Byte address of the entry to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Entry read from memory |

## Verification
A corrupted level counter shows at the memory port within one response. The next read address would take the wrong nine virtual-address bits, or a large-page bit would be honoured at the wrong depth. Either shows as a wrong `pa_o`, `size_o` or `fault_level_o` on the very next pulse. A stuck state register shows as `busy_o` or `mem_req_o` failing to drop in the cycle of the pulse, or as a request appearing for a non-canonical address. The bench exposes these by sweeping:

- every stopping level;
- each page size;
- response latencies from zero to several cycles;
- every single-bit canonical violation.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ptw_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE        = 2'd0,
        CAUSE_NOT_PRESENT = 2'd1,
        CAUSE_NONCANON    = 2'd2
    } ptw_cause_e;

    localparam int PTW_PRESENT_BIT = 0;
    localparam int PTW_LARGE_BIT   = 7;
    localparam int PTW_NOEXEC_BIT  = 63;

endpackage

// File: rtl/ptw_canon_chk.sv
module ptw_canon_chk #(
    parameter int ADDR_W = 64,
    parameter int VA_W   = 48
) (
    input  logic [ADDR_W-1:0] va_i,
    output logic              canon_o
);
    localparam int TOP_W = ADDR_W - VA_W + 1;

    logic [TOP_W-1:0] upper;

    assign upper   = va_i[ADDR_W-1:VA_W-1];
    assign canon_o = (&upper) | ~(|upper);

endmodule

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 4,
    parameter int LVL_W  = 2
) (
    input  logic [ADDR_W-1:0] va_i,
    input  logic [LVL_W-1:0]  lvl_i,
    output logic [IDX_W-1:0]  idx_o
);
    logic [IDX_W-1:0] idx_arr [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_arr[g] = va_i[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    assign idx_o = idx_arr[lvl_i];

endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
    import ptw_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PA_W      = 52,
    parameter int IDX_W     = 9,
    parameter int OFF_W     = 12,
    parameter int LEVELS    = 4,
    parameter int LVL_W     = 2,
    parameter int LARGE_MAX = 2
) (
    input  logic [63:0]           entry_i,
    input  logic [ADDR_W-1:0]     va_i,
    input  logic [LVL_W-1:0]      lvl_i,
    output logic                  present_o,
    output logic                  noexec_o,
    output logic                  leaf_o,
    output logic [LVL_W-1:0]      size_o,
    output logic [PA_W-1:0]       leaf_pa_o,
    output logic [PA_W-OFF_W-1:0] next_base_o
);
    logic            leaf_arr [LEVELS];
    logic [PA_W-1:0] pa_arr   [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam int SPAN = LEVELS - 1 - g;
        localparam int OB   = OFF_W + IDX_W*SPAN;
        localparam logic [PA_W-1:0] MASK = {{(PA_W-OB){1'b0}}, {OB{1'b1}}};

        if (SPAN == 0) begin : g_last
            assign leaf_arr[g] = 1'b1;
        end else if (SPAN <= LARGE_MAX) begin : g_large
            assign leaf_arr[g] = entry_i[PTW_LARGE_BIT];
        end else begin : g_inner
            assign leaf_arr[g] = 1'b0;
        end

        assign pa_arr[g] = (entry_i[PA_W-1:0] & ~MASK) | (va_i[PA_W-1:0] & MASK);
    end

    assign present_o   = entry_i[PTW_PRESENT_BIT];
    assign noexec_o    = entry_i[PTW_NOEXEC_BIT];
    assign leaf_o      = leaf_arr[lvl_i];
    assign leaf_pa_o   = pa_arr[lvl_i];
    assign size_o      = LVL_W'(LEVELS-1) - lvl_i;
    assign next_base_o = entry_i[PA_W-1:OFF_W];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int PA_W   = 52,
    parameter int VA_W   = 48,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [63:0]              va_i,
    input  logic [63:0]              ptbr_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     fault_o,
    output logic [PA_W-1:0]          pa_o,
    output logic [$clog2(LEVELS)-1:0] size_o,
    output logic                     nx_o,
    output logic [1:0]               cause_o,
    output logic [$clog2(LEVELS)-1:0] fault_level_o,
    output logic [63:0]              fault_va_o,
    output logic                     mem_req_o,
    output logic [PA_W-1:0]          mem_addr_o,
    input  logic                     mem_rvalid_i,
    input  logic [63:0]              mem_rdata_i
);
    localparam int ADDR_W = 64;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int ENT_B  = OFF_W - IDX_W;

    typedef struct packed {
        ptw_state_e       st;
        logic [LVL_W-1:0] lvl;
        logic [ADDR_W-1:0] va;
        logic [PA_W-1:0]  addr;
        logic             nx;
        logic [PA_W-1:0]  pa;
        logic [LVL_W-1:0] size;
        logic             done;
        logic             fault;
        ptw_cause_e       cause;
    } walk_t;

    walk_t walk_d, walk_q;

    logic                  canon;
    logic [ADDR_W-1:0]     sel_va;
    logic [LVL_W-1:0]      sel_lvl;
    logic [IDX_W-1:0]      idx;
    logic                  ent_present;
    logic                  ent_nx;
    logic                  ent_leaf;
    logic [LVL_W-1:0]      ent_size;
    logic [PA_W-1:0]       ent_pa;
    logic [PA_W-OFF_W-1:0] ent_base;

    assign sel_va  = (walk_q.st == ST_IDLE) ? va_i : walk_q.va;
    assign sel_lvl = (walk_q.st == ST_IDLE) ? '0 : walk_q.lvl + LVL_W'(1);

    ptw_canon_chk #(
        .ADDR_W (ADDR_W),
        .VA_W   (VA_W)
    ) u_canon (
        .va_i    (va_i),
        .canon_o (canon)
    );

    ptw_idx_sel #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .LEVELS (LEVELS),
        .LVL_W  (LVL_W)
    ) u_idx (
        .va_i  (sel_va),
        .lvl_i (sel_lvl),
        .idx_o (idx)
    );

    ptw_entry_dec #(
        .ADDR_W    (ADDR_W),
        .PA_W      (PA_W),
        .IDX_W     (IDX_W),
        .OFF_W     (OFF_W),
        .LEVELS    (LEVELS),
        .LVL_W     (LVL_W),
        .LARGE_MAX (2)
    ) u_dec (
        .entry_i     (mem_rdata_i),
        .va_i        (walk_q.va),
        .lvl_i       (walk_q.lvl),
        .present_o   (ent_present),
        .noexec_o    (ent_nx),
        .leaf_o      (ent_leaf),
        .size_o      (ent_size),
        .leaf_pa_o   (ent_pa),
        .next_base_o (ent_base)
    );

    always_comb begin
        walk_d       = walk_q;
        walk_d.done  = 1'b0;
        walk_d.fault = 1'b0;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    walk_d.va    = va_i;
                    walk_d.lvl   = '0;
                    walk_d.nx    = 1'b0;
                    walk_d.cause = CAUSE_NONE;
                    if (!canon) begin
                        walk_d.fault = 1'b1;
                        walk_d.cause = CAUSE_NONCANON;
                    end else begin
                        walk_d.st   = ST_WAIT;
                        walk_d.addr = {ptbr_i[PA_W-1:OFF_W], idx, {ENT_B{1'b0}}};
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    walk_d.nx = walk_q.nx | ent_nx;
                    if (!ent_present) begin
                        walk_d.st    = ST_IDLE;
                        walk_d.fault = 1'b1;
                        walk_d.cause = CAUSE_NOT_PRESENT;
                    end else if (ent_leaf) begin
                        walk_d.st   = ST_IDLE;
                        walk_d.done = 1'b1;
                        walk_d.pa   = ent_pa;
                        walk_d.size = ent_size;
                    end else begin
                        walk_d.lvl  = walk_q.lvl + LVL_W'(1);
                        walk_d.addr = {ent_base, idx, {ENT_B{1'b0}}};
                    end
                end
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy_o        = (walk_q.st == ST_WAIT);
    assign mem_req_o     = (walk_q.st == ST_WAIT);
    assign mem_addr_o    = walk_q.addr;
    assign done_o        = walk_q.done;
    assign fault_o       = walk_q.fault;
    assign pa_o          = walk_q.pa;
    assign size_o        = walk_q.size;
    assign nx_o          = walk_q.nx;
    assign cause_o       = walk_q.cause;
    assign fault_level_o = walk_q.lvl;
    assign fault_va_o    = walk_q.va;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int PA_W   = 52,
    parameter int VA_W   = 48,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LVL_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [63:0]      va_i,
    input logic [63:0]      ptbr_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             fault_o,
    input logic [1:0]       cause_o,
    input logic [LVL_W-1:0] fault_level_o,
    input logic [63:0]      fault_va_o,
    input logic             mem_req_o,
    input logic [PA_W-1:0]  mem_addr_o,
    input logic             mem_rvalid_i,
    input logic [63:0]      mem_rdata_i
);
    logic [64-VA_W:0] va_top;
    logic             va_ok;

    assign va_top = va_i[63:VA_W-1];
    assign va_ok  = (va_top == '0) || (va_top == '1);

    AST_NONCANON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !va_ok) |=> (fault_o && cause_o == 2'd2 && fault_level_o == '0
            && !mem_req_o && fault_va_o == $past(va_i))) else $error("AST_NONCANON_FAULT"); // R1

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && va_ok) |=> (mem_req_o && mem_addr_o ==
            {$past(ptbr_i[PA_W-1:OFF_W]), $past(va_i[VA_W-1 -: IDX_W]), 3'b000})) else $error("AST_FIRST_ADDR"); // R2

    AST_NEXT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rvalid_i) |=> (!mem_req_o
            || mem_addr_o[PA_W-1:OFF_W] == $past(mem_rdata_i[PA_W-1:OFF_W]))) else $error("AST_NEXT_BASE"); // R3

    AST_ABSENT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rvalid_i && !mem_rdata_i[0]) |=> (fault_o && cause_o == 2'd1 && !busy_o)) else $error("AST_ABSENT_FAULT"); // R4

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_rvalid_i) |=> busy_o) else $error("AST_BUSY_HOLD"); // R9

    AST_END_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fault_o) |-> !busy_o) else $error("AST_END_NOT_BUSY"); // R9

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))) else $error("AST_REQ_STABLE"); // R10

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o)) else $error("AST_PULSE_EXCL"); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fault_o) |=> !(done_o || fault_o)) else $error("AST_DONE_PULSE"); // R11

endmodule

bind pt_walker pt_walker_chk #(
    .PA_W  (PA_W),
    .VA_W  (VA_W),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W),
    .LVL_W ($clog2(LEVELS))
) u_pt_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .va_i          (va_i),
    .ptbr_i        (ptbr_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .fault_o       (fault_o),
    .cause_o       (cause_o),
    .fault_level_o (fault_level_o),
    .fault_va_o    (fault_va_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_rvalid_i  (mem_rvalid_i),
    .mem_rdata_i   (mem_rdata_i)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] va = '0;
    logic [63:0] ptbr = '0;
    logic        busy, done, fault, nx, mem_req;
    logic [51:0] pa, mem_addr;
    logic [1:0]  size, cause, flvl;
    logic [63:0] fva;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int tests = 0;
    int fails = 0;

    logic [63:0] ent [4];
    logic [51:0] got_addr [4];
    int  req_cnt = 0;
    int  lat = 0;
    int  cd = 0;
    bit  pend = 1'b0;
    bit  spur = 1'b0;

    always #2 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start), .va_i(va), .ptbr_i(ptbr),
        .busy_o(busy), .done_o(done), .fault_o(fault), .pa_o(pa), .size_o(size),
        .nx_o(nx), .cause_o(cause), .fault_level_o(flvl), .fault_va_o(fva),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
    );

    // memory model: one outstanding read, latency lat cycles
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
        end else if (spur) begin
            mem_rvalid = 1'b1;
            mem_rdata  = '1;
            spur       = 1'b0;
        end else if (mem_req) begin
            if (!pend) begin
                pend = 1'b1;
                cd   = lat;
                if (req_cnt < 4) got_addr[req_cnt] = mem_addr;
            end
            if (cd == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = (req_cnt < 4) ? ent[req_cnt] : 64'h0;
                req_cnt++;
                pend = 1'b0;
            end else begin
                cd--;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [39:0] frame, input bit p, input bit ps,
                                       input bit nxb, input logic [10:0] junk);
        logic [63:0] e;
        e        = '0;
        e[51:12] = frame;
        e[62:52] = junk;
        e[11:8]  = junk[3:0];
        e[6:1]   = junk[9:4];
        e[7]     = ps;
        e[0]     = p;
        e[63]    = nxb;
        return e;
    endfunction

    function automatic logic [63:0] canon_va(input int s, input bit upper);
        logic [63:0] v;
        v = 64'(s) * 64'h9E37_79B9_7F4A_7C15;
        v[47] = upper;
        v[63:48] = {16{upper}};
        return v;
    endfunction

    // drive one walk and check every output against values derived from the requirements
    task automatic walk(input logic [63:0] v, input logic [63:0] base, input int latency, input bit poke);
        int          n;
        bit          seen_done, seen_fault, stop, canon_ok;
        int          kind, xlvl, nreq;
        logic [51:0] xaddr [4];
        logic [51:0] xpa, mask;
        logic [1:0]  xsize;
        bit          xnx;
        lat = latency; req_cnt = 0;
        kind = 0; xlvl = 0; nreq = 0; xpa = '0; xsize = '0; xnx = 1'b0; stop = 1'b0;
        canon_ok = (v[63:47] == '0) || (v[63:47] == '1);
        if (!canon_ok) begin
            kind = 2;
        end else begin
            for (int l = 0; l < 4; l++) begin
                if (!stop) begin
                    xaddr[l] = (l == 0) ? {base[51:12], v[47:39], 3'b000}
                                        : {ent[l-1][51:12], v[47-9*l -: 9], 3'b000};
                    nreq = l + 1;
                    xnx  = xnx | ent[l][63];
                    if (!ent[l][0]) begin
                        kind = 1; xlvl = l; stop = 1'b1;
                    end else if (((l == 1 || l == 2) && ent[l][7]) || l == 3) begin
                        mask  = (52'd1 << (12 + 9*(3-l))) - 52'd1;
                        xpa   = (ent[l][51:0] & ~mask) | (v[51:0] & mask);
                        xsize = 2'(3 - l);
                        stop  = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        va = v; ptbr = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0; va = ~v; ptbr = ~base;
        if (poke) chk(busy == 1'b1, "R9 busy after start", 64'(busy), 64'd1);
        n = 0; seen_done = 1'b0; seen_fault = 1'b0;
        while (!(done || fault) && n < 200) begin
            if (poke && n == 1) begin start = 1'b1; va = canon_va(77, 1'b0); end
            if (poke && n == 2) start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        seen_done = done; seen_fault = fault;
        chk(n < 200, "R9 walk finishes", 64'(n), 64'd0);
        chk(busy == 1'b0, "R9 not busy at end", 64'(busy), 64'd0);
        chk(!(seen_done && seen_fault), "R11 exclusive pulses", 64'({seen_done, seen_fault}), 64'd0);
        chk(req_cnt == nreq, "R10 request count", 64'(req_cnt), 64'(nreq));
        for (int l = 0; l < 4; l++)
            if (l < nreq && l < req_cnt)
                chk(got_addr[l] == xaddr[l], (l == 0) ? "R2 first address" : "R3 next address",
                    64'(got_addr[l]), 64'(xaddr[l]));
        if (kind == 0) begin
            chk(seen_done, "R11 done pulse", 64'(seen_done), 64'd1);
            chk(pa == xpa, (xsize == 2) ? "R5 1G address" : (xsize == 1) ? "R6 2M address" : "R7 4K address",
                64'(pa), 64'(xpa));
            chk(size == xsize, "R5 R6 R7 size", 64'(size), 64'(xsize));
            chk(nx == xnx, "R8 nx summary", 64'(nx), 64'(xnx));
            chk(cause == 2'd0, "R11 cause none", 64'(cause), 64'd0);
        end else begin
            chk(seen_fault, "R4 fault pulse", 64'(seen_fault), 64'd1);
            chk(cause == 2'(kind), (kind == 2) ? "R1 cause" : "R4 cause", 64'(cause), 64'(kind));
            chk(flvl == 2'(xlvl), (kind == 2) ? "R1 level" : "R4 level", 64'(flvl), 64'(xlvl));
            chk(fva == v, (kind == 2) ? "R1 fault va" : "R4 fault va", fva, v);
            if (kind == 2) chk(n == 0, "R1 immediate fault", 64'(n), 64'd0);
        end
        @(negedge clk);
        chk(!done && !fault, "R11 single-cycle pulse", 64'({done, fault}), 64'd0);
    endtask

    task automatic build_chain(input int s, input int leaf_lvl, input int absent_lvl, input int nx_lvl);
        for (int l = 0; l < 4; l++) begin
            ent[l] = mk(40'(s*7919 + l*104729 + 40'h1_2345), (l != absent_lvl),
                        (l == leaf_lvl) || (l == 0) || ((l == 3) && s[0]),
                        (l == nx_lvl), 11'(s*37 + l*5 + 11'h2A5));
        end
    endtask

    initial begin
        #(4*190000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] b;
        bit          seen;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && fault == 0 && mem_req == 0, "R11 reset state",
            64'({busy, done, fault, mem_req}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: stray valid while idle has no effect
        spur = 1'b1; seen = 1'b0;
        repeat (4) begin @(negedge clk); seen = seen | done | fault | busy | mem_req; end
        chk(!seen, "R10 stray valid ignored", 64'(seen), 64'd0);

        // R5 R6 R7: leaf at each depth, several addresses and latencies
        for (int s = 0; s < 6; s++)
            for (int leaf = 1; leaf < 4; leaf++)
                for (int lt = 0; lt < 4; lt++) begin
                    build_chain(s, leaf, 9, 9);
                    b = {canon_va(s+3, 1'b0)[63:12], 12'hABC};
                    walk(canon_va(s*4 + lt, s[0]), b, lt, 1'b0);
                end

        // R4: absent entry at each level
        for (int f = 0; f < 4; f++)
            for (int lt = 0; lt < 3; lt++) begin
                build_chain(f + 10, 9, f, 9);
                walk(canon_va(f*3 + lt + 50, lt[0]), 64'h0000_0ABC_DEF0_1FFF, lt, 1'b0);
            end

        // R8: no-execute on one level at a time, 4K leaf
        for (int x = 0; x < 4; x++) begin
            build_chain(20 + x, 9, 9, x);
            ent[0][7] = 1'b1;
            walk(canon_va(60 + x, 1'b1), 64'h0000_1234_5678_9000, 1, 1'b0);
        end

        // R1: each single-bit canonical violation
        for (int bt = 47; bt < 64; bt++) begin
            logic [63:0] v;
            v = canon_va(bt, bt[0]);
            v[bt] = ~v[bt];
            build_chain(0, 3, 9, 9);
            walk(v, 64'h0000_0000_0010_0000, 0, 1'b0);
        end

        // R9: start pulsed while busy is ignored
        build_chain(31, 3, 9, 9);
        walk(canon_va(99, 1'b0), 64'h0000_0000_0777_7000, 5, 1'b1);
        build_chain(32, 2, 9, 9);
        walk(canon_va(98, 1'b1), 64'h0000_0000_0555_5000, 3, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule